// File: doc/BRIEF.md
# Multi-mode status register bank

This block is a small bank of register fields that sit behind a single-cycle host read/write bus. Each register in the bank takes one access behaviour, chosen at build time through a packed kind map parameter. The kinds are plain storage, a direct view of a hardware input, a one-flop copy of a hardware input, level latches, edge-captured interrupt flags, interrupt enables, a value sampled once after reset, a write-strobe register, and a register that software sets and hardware clears. Latches and interrupt flags clear either on a read or through a written mask.

The host presents `addr`, `wdata` and a one-cycle `wr_en` or `rd_en`. Read data is returned combinationally in the same cycle as `rd_en`. Any clear caused by that read lands on the clock edge that ends the access. Each interrupt register is gated by the enable register at the next address, when that register has the enable kind. The `irq` output is a registered OR of every pending, enabled interrupt bit.

Top module: `status_regbank`

## Requirements
- R1: A write stores `wdata` into a plain storage register, and a read returns it in the same cycle. Addresses at or above the register count ignore writes and read as zero.
- R2: A pass-through register reads the current value of its hardware input in the very cycle of the read. Writes to it have no effect.
- R3: A registered-view register returns the hardware input as it stood one clock earlier. Writes to it have no effect.
- R4: A level latch sets each bit while its input bit is 1 (high kind) or 0 (low kind). Bits stay set until cleared. In the read-clear style, a completed read returns the bits and then clears them all on the edge that ends the read.
- R5: In the mask-clear style, reads leave latch and interrupt bits intact. Writing clears only the bit positions where `wdata` holds a 1.
- R6: When a hardware set and a software clear of the same bit fall in one cycle, the bit ends set.
- R7: A rising-kind interrupt bit sets on a 0-to-1 step of its input, and a falling-kind bit on a 1-to-0 step. A steady input level sets nothing. Edges are detected from the second clock after reset release onward.
- R8: An interrupt bit drives `irq` only when the same bit position of the enable register at the next address is 1. `irq` rises on the clock after the bit becomes pending and enabled.
- R9: `irq` returns to 0 on the clock after the last pending enabled bit clears. It is 0 after reset.
- R10: The sample-after-reset register loads its hardware input on the first clock after reset release. From then on it behaves as plain storage.
- R11: Writing the strobe register stores the value and drives it on that register's `hw_out` slice for exactly one clock, starting after the write edge. At all other times the slice is zero.
- R12: The hardware-cleared register is written by software and cleared per bit by `hw_clr`. A software write in the same cycle takes precedence. Its stored value is visible on its `hw_out` slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write access |
| rd_en | input | 1 | One-cycle read access |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data or clear mask |
| rdata | output | DATA_W | Read data, valid in the `rd_en` cycle |
| hw_in | input | NUM_REGS*DATA_W | Per-register hardware inputs, register i at slice i |
| hw_clr | input | NUM_REGS*DATA_W | Per-register hardware clear bits |
| hw_out | output | NUM_REGS*DATA_W | Per-register values or strobes toward hardware |
| irq | output | 1 | Registered OR of pending enabled interrupt bits |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume each access lasts exactly one cycle, and that hardware inputs to rising-edge registers carry no meaning before reset release. The stimulus drives every access as a single-cycle pulse, one at a time. It holds edge inputs at their idle level through reset and changes hardware inputs only between clock edges, so each edge, latch set and clear falls in a known cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_RW   = 4'd0,
    K_RO   = 4'd1,
    K_RV   = 4'd2,
    K_LHSC = 4'd3,
    K_LLSC = 4'd4,
    K_LHMK = 4'd5,
    K_LLMK = 4'd6,
    K_IRSC = 4'd7,
    K_IFSC = 4'd8,
    K_IRMK = 4'd9,
    K_IFMK = 4'd10,
    K_IEN  = 4'd11,
    K_LOR  = 4'd12,
    K_WSTB = 4'd13,
    K_RWSC = 4'd14
  } field_kind_e;

  // register 17 down to register 0
  localparam int DEFAULT_REGS = 18;
  localparam logic [DEFAULT_REGS*KIND_W-1:0] DEFAULT_MAP = {
    K_RWSC, K_WSTB, K_LOR, K_IEN, K_IFMK, K_IEN, K_IRMK, K_IEN, K_IFSC,
    K_IEN, K_IRSC, K_LLMK, K_LHMK, K_LLSC, K_LHSC, K_RV, K_RO, K_RW
  };

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int NUM_REGS = 18,
  parameter int ADDR_W   = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] wr_vec,
  output logic [NUM_REGS-1:0] rd_vec
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    assign wr_vec[i] = wr_en && (addr == MY_ADDR);
    assign rd_vec[i] = rd_en && (addr == MY_ADDR);
  end

endmodule

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter field_kind_e KIND   = K_RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_in,
  input  logic [DATA_W-1:0] hw_clr,
  input  logic [DATA_W-1:0] ien_in,
  output logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] hw_out,
  output logic [DATA_W-1:0] irq_bits
);

  localparam bit IS_LATCH = (KIND == K_LHSC) || (KIND == K_LLSC) ||
                            (KIND == K_LHMK) || (KIND == K_LLMK);
  localparam bit IS_EDGE  = (KIND == K_IRSC) || (KIND == K_IFSC) ||
                            (KIND == K_IRMK) || (KIND == K_IFMK);
  localparam bit CLR_RD   = (KIND == K_LHSC) || (KIND == K_LLSC) ||
                            (KIND == K_IRSC) || (KIND == K_IFSC);
  localparam bit IS_STORE = (KIND == K_RW) || (KIND == K_IEN) ||
                            (KIND == K_LOR) || (KIND == K_RWSC);

  logic [DATA_W-1:0] q, q_next;
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] pulse_q, pulse_next;
  logic              loaded_q;
  logic [DATA_W-1:0] set_v, clr_v;
  logic              q_en, prev_en, pulse_en;

  // hardware set events
  always_comb begin
    set_v = '0;
    unique case (KIND)
      K_LHSC, K_LHMK: set_v = hw_in;
      K_LLSC, K_LLMK: set_v = ~hw_in;
      K_IRSC, K_IRMK: set_v = loaded_q ? (hw_in & ~prev_q) : '0;
      K_IFSC, K_IFMK: set_v = loaded_q ? (~hw_in & prev_q) : '0;
      default:        set_v = '0;
    endcase
  end

  // software clear events
  always_comb begin
    clr_v = '0;
    if (IS_LATCH || IS_EDGE) begin
      if (CLR_RD) clr_v = {DATA_W{rd_stb}};
      else        clr_v = wr_stb ? wdata : '0;
    end
  end

  // next state
  always_comb begin
    q_next     = q;
    pulse_next = '0;
    unique case (KIND)
      K_RW, K_IEN: if (wr_stb) q_next = wdata;
      K_RO:        q_next = '0;
      K_RV:        q_next = hw_in;
      K_LOR: begin
        if (!loaded_q)   q_next = hw_in;
        else if (wr_stb) q_next = wdata;
      end
      K_WSTB: begin
        if (wr_stb) begin
          q_next     = wdata;
          pulse_next = wdata;
        end
      end
      K_RWSC: q_next = wr_stb ? wdata : (q & ~hw_clr);
      default: q_next = (q & ~clr_v) | set_v;
    endcase
  end

  assign q_en     = (q_next != q);
  assign prev_en  = IS_EDGE;
  assign pulse_en = (KIND == K_WSTB) && (wr_stb || (pulse_q != '0));

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      prev_q   <= '0;
      pulse_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (q_en)      q        <= q_next;
      if (prev_en)   prev_q   <= hw_in;
      if (pulse_en)  pulse_q  <= pulse_next;
      if (!loaded_q) loaded_q <= 1'b1;
    end
  end

  // outputs
  assign value    = (KIND == K_RO) ? hw_in : q;
  assign irq_bits = IS_EDGE ? (q & ien_in) : '0;
  assign hw_out   = (KIND == K_WSTB) ? pulse_q : (IS_STORE ? q : '0);

  logic unused_ok;
  assign unused_ok = ^{hw_clr, ien_in, rd_stb};

  // checks next to the logic they guard
  if (IS_LATCH || IS_EDGE) begin : g_chk_sticky
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !wr_stb) |=> ((q & $past(q)) == $past(q)))
      else $error("sticky bit dropped without a clear access");
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)))
      else $error("set event lost");
  end

  if (IS_EDGE) begin : g_chk_edge
    p_steady_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_in == $past(hw_in)) && loaded_q && !rd_stb && !wr_stb) |=> (q == $past(q)))
      else $error("edge flag changed on a steady input");
  end

  if (KIND == K_LOR) begin : g_chk_lor
    p_lor_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded_q |=> (value == $past(hw_in)))
      else $error("sample after reset missed");
  end

  if (KIND == K_WSTB) begin : g_chk_stb
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> (hw_out == '0))
      else $error("strobe without a write");
  end

  if (KIND == K_RWSC) begin : g_chk_rwsc
    p_hw_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ((value & $past(hw_clr)) == '0))
      else $error("hardware clear ignored");
  end

endmodule

// File: rtl/regbank_irq.sv
module regbank_irq #(
  parameter int NUM_REGS = 18,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS*DATA_W-1:0] bits,
  output logic                       irq
);

  logic any_next;
  logic irq_q;

  always_comb any_next = |bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_next;
  end

  assign irq = irq_q;

endmodule

// File: rtl/status_regbank.sv
module status_regbank
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = DEFAULT_REGS,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter logic [NUM_REGS*KIND_W-1:0] KIND_MAP = DEFAULT_MAP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NUM_REGS*DATA_W-1:0] hw_in,
  input  logic [NUM_REGS*DATA_W-1:0] hw_clr,
  output logic [NUM_REGS*DATA_W-1:0] hw_out,
  output logic                       irq
);

  logic [NUM_REGS-1:0]        wr_vec, rd_vec;
  logic [DATA_W-1:0]          val_w [NUM_REGS];
  logic [DATA_W-1:0]          ien_w [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] irq_bits;

  regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_decode (
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wr_vec (wr_vec),
    .rd_vec (rd_vec)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam field_kind_e MY_KIND = field_kind_e'(KIND_MAP[KIND_W*i +: KIND_W]);

    if (i + 1 < NUM_REGS) begin : g_en
      localparam field_kind_e NEXT_KIND = field_kind_e'(KIND_MAP[KIND_W*(i+1) +: KIND_W]);
      assign ien_w[i] = (NEXT_KIND == K_IEN) ? val_w[i+1] : '0;
    end else begin : g_no_en
      assign ien_w[i] = '0;
    end

    regbank_field #(.DATA_W(DATA_W), .KIND(MY_KIND)) i_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_vec[i]),
      .rd_stb   (rd_vec[i]),
      .wdata    (wdata),
      .hw_in    (hw_in[DATA_W*i +: DATA_W]),
      .hw_clr   (hw_clr[DATA_W*i +: DATA_W]),
      .ien_in   (ien_w[i]),
      .value    (val_w[i]),
      .hw_out   (hw_out[DATA_W*i +: DATA_W]),
      .irq_bits (irq_bits[DATA_W*i +: DATA_W])
    );
  end

  // read multiplexer
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_vec[i]) rdata = rdata | val_w[i];
    end
  end

  regbank_irq #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (irq_bits),
    .irq   (irq)
  );

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_bits == '0) |=> !irq)
    else $error("irq held with nothing pending");

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_bits) != '0))
    else $error("irq rose with nothing pending");

  p_single_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vec, rd_vec}))
    else $error("more than one register accessed");

endmodule

// File: tb/test_status_regbank.sv
module test_status_regbank;

  localparam int NR = 18;
  localparam int DW = 8;
  localparam int AW = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en, rd_en;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdata;
  logic [DW-1:0]   rdata;
  logic [NR*DW-1:0] hw_in, hw_clr, hw_out;
  logic            irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         req;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  status_regbank i_status_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hw_in(hw_in), .hw_clr(hw_clr),
    .hw_out(hw_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hw(input int idx, input logic [DW-1:0] v);
    hw_in[idx*DW +: DW] = v;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] e, input string req);
    sb_item_t it;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // monitor: compares read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_en) begin
        if (sb_q.size() == 0) begin
          chk("R1 unexpected read", 32'(rdata), 32'hDEAD);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          chk(it.req, 32'(rdata), 32'(it.exp));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    hw_in = '0; hw_clr = '0;
    set_hw(4, 8'hFF); set_hw(6, 8'hFF); set_hw(9, 8'hFF); set_hw(13, 8'hFF);
    set_hw(15, 8'h5A);
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // reset state
    chk("R9 irq after reset", 32'(irq), 0);
    do_read(0, 8'h00, "R1 reset value");

    // R10 sampled after reset
    set_hw(15, 8'h00);
    do_read(15, 8'h5A, "R10 sampled value");
    do_write(15, 8'h33);
    do_read(15, 8'h33, "R10 write after sample");

    // R1 plain storage and range
    do_write(0, 8'hA5);
    do_read(0, 8'hA5, "R1 read back");
    do_write(20, 8'hFF);
    do_read(20, 8'h00, "R1 out of range");
    do_read(0, 8'hA5, "R1 untouched by out-of-range write");

    // R2 pass-through, no delay
    set_hw(1, 8'h3C);
    do_read(1, 8'h3C, "R2 same cycle");
    do_write(1, 8'hFF);
    set_hw(1, 8'hC3);
    do_read(1, 8'hC3, "R2 write ignored");

    // R3 registered view
    set_hw(2, 8'h11);
    do_read(2, 8'h00, "R3 old value");
    do_read(2, 8'h11, "R3 one clock later");
    do_write(2, 8'hFF);
    do_read(2, 8'h11, "R3 write ignored");

    // R4 latches, read-clear
    set_hw(3, 8'h05); tick(1); set_hw(3, 8'h00); tick(1);
    do_read(3, 8'h05, "R4 high latch held");
    do_read(3, 8'h00, "R4 high latch cleared by read");
    set_hw(4, 8'hF0); tick(1); set_hw(4, 8'hFF); tick(1);
    do_read(4, 8'h0F, "R4 low latch held");
    do_read(4, 8'h00, "R4 low latch cleared by read");

    // R5 mask clear
    set_hw(5, 8'h3C); tick(1); set_hw(5, 8'h00); tick(1);
    do_read(5, 8'h3C, "R5 latch set");
    do_read(5, 8'h3C, "R5 read does not clear");
    do_write(5, 8'h0C);
    do_read(5, 8'h30, "R5 masked clear");
    set_hw(6, 8'hFE); tick(1); set_hw(6, 8'hFF); tick(1);
    do_read(6, 8'h01, "R5 low latch set");
    do_write(6, 8'h01);
    do_read(6, 8'h00, "R5 low latch masked clear");

    // R6 set beats clear
    set_hw(5, 8'h10);
    do_write(5, 8'h30);
    set_hw(5, 8'h00);
    do_read(5, 8'h10, "R6 set wins over mask clear");
    set_hw(3, 8'h01); tick(1);
    do_read(3, 8'h01, "R6 read while set");
    set_hw(3, 8'h00);
    do_read(3, 8'h01, "R6 set wins over read clear");
    do_read(3, 8'h00, "R6 cleared afterwards");

    // R7/R8/R9 rising edge, read-clear, enabled bit 0
    do_write(8, 8'h01);
    set_hw(7, 8'h01); tick(2);
    chk("R8 irq raised by enabled edge", 32'(irq), 1);
    do_read(7, 8'h01, "R7 rising edge captured");
    do_read(7, 8'h00, "R7 steady high sets nothing");
    chk("R9 irq dropped after clear", 32'(irq), 0);
    set_hw(7, 8'h03); tick(2);
    chk("R8 disabled bit keeps irq low", 32'(irq), 0);
    do_read(7, 8'h02, "R7 second rising bit");
    do_read(7, 8'h00, "R7 cleared by read");
    set_hw(7, 8'h00); tick(1);
    do_read(7, 8'h00, "R7 falling input ignored by rising kind");

    // R7/R8/R9 falling edge, mask clear
    do_write(14, 8'h80);
    set_hw(13, 8'h7F); tick(2);
    chk("R8 irq raised by falling edge", 32'(irq), 1);
    do_read(13, 8'h80, "R7 falling edge captured");
    do_read(13, 8'h80, "R5 interrupt not cleared by read");
    do_write(13, 8'h80);
    tick(1);
    chk("R9 irq dropped after mask clear", 32'(irq), 0);
    set_hw(13, 8'hFF); tick(1);
    do_read(13, 8'h00, "R7 rising input ignored by falling kind");

    // R11 write strobe
    do_write(16, 8'h81);
    chk("R11 strobe cycle", 32'(hw_out[16*DW +: DW]), 32'h81);
    tick(1);
    chk("R11 strobe over", 32'(hw_out[16*DW +: DW]), 0);
    do_read(16, 8'h81, "R11 stored value");

    // R12 hardware-cleared register
    do_write(17, 8'h0F);
    do_read(17, 8'h0F, "R12 written");
    hw_clr[17*DW +: DW] = 8'h03; tick(1); hw_clr[17*DW +: DW] = 8'h00;
    do_read(17, 8'h0C, "R12 hardware clear");
    chk("R12 hw_out view", 32'(hw_out[17*DW +: DW]), 32'h0C);
    hw_clr[17*DW +: DW] = 8'hFF;
    do_write(17, 8'h0F);
    hw_clr[17*DW +: DW] = 8'h00;
    do_read(17, 8'h0F, "R12 write beats clear");

    tick(3);
    chk("R1 scoreboard drained", 32'(sb_q.size()), 0);
    finish_run();
  end

endmodule